// File: doc/BRIEF.md
# Key Generator Control Sequencer

This block is the control and status front end of a hardware unique key engine. Software drives it over a simple 32-bit register bus. A launch strobe starts the preparation phase. When the datapath reports that preparation is complete, the sequencer pauses in one of two phases: LOAD when it is recovering an existing key, or GAIN when it is generating a new one. Software must then issue a resume strobe before processing may run. Once processing completes, the sequencer enters BUSY for post-processing. When post-processing completes, it returns to IDLE and latches the outcome.

Each completion raises one of three interrupt sources: prep, proc and post. Each source has a raw bit, an enable bit, a masked status bit and a write-one clear bit, and a single interrupt line carries the OR of the masked bits. The outcome is stored as a 2-bit validity code and a 3-bit risk grade supplied by the datapath. The top risk grade forces the code to invalid.

The key derivation datapath is stubbed outside the block. It sees launch and resume pulses, the latched mode and the current phase, and it returns three done pulses and a risk grade.

Top module: `ukgen_ctrl`

## Requirements
- R1: After reset: phase reads 0 (IDLE), the raw, enable and masked registers read 0, the mode reads 0, and the result reads 0. The clock control register reads 1, where bit 0 is the register clock force-on and bit 1 is the memory clock force-on. The version register at 0xFC reads 36720704.
- R2: Writing a 1 to bit 1 of the control register (0x24) while in IDLE arms the sequencer and latches config bit 0 (0x20) as the mode, where 1 = generate and 0 = recover. A later prep done pulse moves the phase to LOAD (1) if the mode is 0 or to GAIN (2) if the mode is 1, and sets raw bit 0.
- R3: Writing a 1 to bit 0 of the control register while in LOAD or GAIN allows processing. A later proc done pulse moves the phase to BUSY (3) and sets raw bit 1.
- R4: A post done pulse in BUSY returns the phase to IDLE, sets raw bit 2 and latches the result.
- R5: The result register (0x34) holds the status code in bits [1:0] and the risk grade in bits [4:2]. The status code is 1 (valid) for risk grades 0 to 6 and 2 (invalid) for risk grade 7.
- R6: A strobe or done pulse that does not match the current phase, or that arrives before its arming strobe, changes neither the phase nor the raw bits.
- R7: Writing a 1 to a bit of the clear register (0x14) clears that raw bit (0x08). If an event sets the same bit in the same cycle, the set wins.
- R8: The masked register (0x0C) reads raw AND enable (0x10). The irq output is the OR of the masked bits and follows them one clock later.
- R9: The control and clear registers always read 0. The state register is at 0x28, and unmapped offsets read 0.
- R10: The clock control register (0x04) bits are read/write and drive the clk_force_reg and clk_force_mem outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dp_prep_done | input | 1 | Preparation complete pulse |
| dp_proc_done | input | 1 | Processing complete pulse |
| dp_post_done | input | 1 | Post-processing complete pulse |
| dp_risk | input | 3 | Risk grade from datapath |
| dp_start | output | 1 | Registered pulse on accepted launch |
| dp_resume | output | 1 | Registered pulse on accepted resume |
| dp_mode | output | 1 | Mode latched at launch |
| eng_phase | output | 2 | Current phase |
| clk_force_reg | output | 1 | Register clock force-on |
| clk_force_mem | output | 1 | Memory clock force-on |
| irq | output | 1 | Interrupt line |

## Verification
Writes, strobes and done pulses take effect at the clock edge where they are sampled. A read returns its data on bus_rdata after that edge, and irq lags the masked bits by one further edge. The bench drives every input on the falling edge and holds it across exactly one rising edge. It reads results back on the following falling edge, and it waits one extra cycle before checking irq. The collision case drives a clear write and a prep done pulse in the same cycle, then reads the raw register on the next cycle.

// File: rtl/ukgen_pkg.sv
package ukgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_GAIN = 2'd2,
    PH_BUSY = 2'd3
  } phase_e;

  localparam int NUM_SRC  = 3;
  localparam int RISK_W   = 3;
  localparam int STAT_W   = 2;

  localparam logic [STAT_W-1:0] ST_NONE = 2'd0;
  localparam logic [STAT_W-1:0] ST_OK   = 2'd1;
  localparam logic [STAT_W-1:0] ST_BAD  = 2'd2;
  localparam logic [RISK_W-1:0] RISK_ERR = 3'd7;

  localparam logic [7:0] OFS_CLK   = 8'h04;
  localparam logic [7:0] OFS_RAW   = 8'h08;
  localparam logic [7:0] OFS_MSK   = 8'h0C;
  localparam logic [7:0] OFS_ENA   = 8'h10;
  localparam logic [7:0] OFS_CLR   = 8'h14;
  localparam logic [7:0] OFS_CONF  = 8'h20;
  localparam logic [7:0] OFS_CTRL  = 8'h24;
  localparam logic [7:0] OFS_STATE = 8'h28;
  localparam logic [7:0] OFS_RES   = 8'h34;
  localparam logic [7:0] OFS_VER   = 8'hFC;
endpackage

// File: rtl/ukgen_seq.sv
module ukgen_seq
  import ukgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   launch_req,
  input  logic   resume_req,
  input  logic   mode_sel,
  input  logic   prep_done,
  input  logic   proc_done,
  input  logic   post_done,
  output phase_e phase,
  output logic   mode_q,
  output logic   ev_prep,
  output logic   ev_proc,
  output logic   ev_post,
  output logic   go_o,
  output logic   cont_o
);
  logic armed_q;
  logic running_q;
  logic paused;
  logic launch_ok;
  logic resume_ok;

  always_comb begin
    paused    = (phase == PH_LOAD) || (phase == PH_GAIN);
    launch_ok = launch_req && (phase == PH_IDLE) && !armed_q;
    resume_ok = resume_req && paused && !running_q;
    ev_prep   = (phase == PH_IDLE) && armed_q && prep_done;
    ev_proc   = paused && running_q && proc_done;
    ev_post   = (phase == PH_BUSY) && post_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      armed_q   <= 1'b0;
      running_q <= 1'b0;
      mode_q    <= 1'b0;
      go_o      <= 1'b0;
      cont_o    <= 1'b0;
    end else begin
      go_o   <= launch_ok;
      cont_o <= resume_ok;
      if (launch_ok) begin
        armed_q <= 1'b1;
        mode_q  <= mode_sel;
      end
      if (resume_ok) running_q <= 1'b1;
      if (ev_prep) begin
        armed_q <= 1'b0;
        phase   <= mode_q ? PH_GAIN : PH_LOAD;
      end
      if (ev_proc) begin
        running_q <= 1'b0;
        phase     <= PH_BUSY;
      end
      if (ev_post) phase <= PH_IDLE;
    end
  end
endmodule

// File: rtl/ukgen_irq.sv
module ukgen_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic         ena_we,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] raw_q,
  output logic [N-1:0] ena_q,
  output logic [N-1:0] masked,
  output logic         irq_q
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[i] <= 1'b0;
        ena_q[i] <= 1'b0;
      end else begin
        if (ev[i])                       raw_q[i] <= 1'b1;
        else if (clr_we && wbits[i])     raw_q[i] <= 1'b0;
        if (ena_we)                      ena_q[i] <= wbits[i];
      end
    end
  end

  assign masked = raw_q & ena_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end
endmodule

// File: rtl/ukgen_result.sv
module ukgen_result
  import ukgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [RISK_W-1:0] risk_in,
  output logic [STAT_W-1:0] status_q,
  output logic [RISK_W-1:0] risk_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= ST_NONE;
      risk_q   <= '0;
    end else if (capture) begin
      risk_q   <= risk_in;
      status_q <= (risk_in == RISK_ERR) ? ST_BAD : ST_OK;
    end
  end
endmodule

// File: rtl/ukgen_ctrl.sv
module ukgen_ctrl
  import ukgen_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter logic [27:0] VERSION = 28'd36720704
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dp_prep_done,
  input  logic              dp_proc_done,
  input  logic              dp_post_done,
  input  logic [RISK_W-1:0] dp_risk,
  output logic              dp_start,
  output logic              dp_resume,
  output logic              dp_mode,
  output logic [1:0]        eng_phase,
  output logic              clk_force_reg,
  output logic              clk_force_mem,
  output logic              irq
);
  localparam int RES_W = STAT_W + RISK_W;

  logic               wr_en;
  logic [7:0]         ofs;
  logic               conf_mode_q;
  logic               launch_req;
  logic               resume_req;
  phase_e             phase;
  logic               ev_prep, ev_proc, ev_post;
  logic [NUM_SRC-1:0] irq_raw, irq_ena, irq_msk;
  logic [STAT_W-1:0]  res_status;
  logic [RISK_W-1:0]  res_risk;

  assign ofs        = 8'(bus_addr);
  assign wr_en      = bus_sel && bus_wr;
  assign launch_req = wr_en && (ofs == OFS_CTRL) && bus_wdata[1];
  assign resume_req = wr_en && (ofs == OFS_CTRL) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_force_reg <= 1'b1;
      clk_force_mem <= 1'b0;
      conf_mode_q   <= 1'b0;
    end else if (wr_en) begin
      if (ofs == OFS_CLK) begin
        clk_force_reg <= bus_wdata[0];
        clk_force_mem <= bus_wdata[1];
      end
      if (ofs == OFS_CONF) conf_mode_q <= bus_wdata[0];
    end
  end

  ukgen_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .launch_req(launch_req),
    .resume_req(resume_req),
    .mode_sel  (conf_mode_q),
    .prep_done (dp_prep_done),
    .proc_done (dp_proc_done),
    .post_done (dp_post_done),
    .phase     (phase),
    .mode_q    (dp_mode),
    .ev_prep   (ev_prep),
    .ev_proc   (ev_proc),
    .ev_post   (ev_post),
    .go_o      (dp_start),
    .cont_o    (dp_resume)
  );

  ukgen_irq #(.N(NUM_SRC)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .ev    ({ev_post, ev_proc, ev_prep}),
    .clr_we(wr_en && (ofs == OFS_CLR)),
    .ena_we(wr_en && (ofs == OFS_ENA)),
    .wbits (bus_wdata[NUM_SRC-1:0]),
    .raw_q (irq_raw),
    .ena_q (irq_ena),
    .masked(irq_msk),
    .irq_q (irq)
  );

  ukgen_result u_res (
    .clk     (clk),
    .rst     (rst),
    .capture (ev_post),
    .risk_in (dp_risk),
    .status_q(res_status),
    .risk_q  (res_risk)
  );

  assign eng_phase = phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      unique case (ofs)
        OFS_CLK:   bus_rdata <= DATA_W'({clk_force_mem, clk_force_reg});
        OFS_RAW:   bus_rdata <= DATA_W'(irq_raw);
        OFS_MSK:   bus_rdata <= DATA_W'(irq_msk);
        OFS_ENA:   bus_rdata <= DATA_W'(irq_ena);
        OFS_CONF:  bus_rdata <= DATA_W'(conf_mode_q);
        OFS_STATE: bus_rdata <= DATA_W'(phase);
        OFS_RES:   bus_rdata <= DATA_W'({res_risk, res_status});
        OFS_VER:   bus_rdata <= DATA_W'(VERSION);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  logic [RES_W-1:0] unused_res;
  assign unused_res = {res_risk, res_status};
endmodule

// File: rtl/ukgen_ctrl_chk.sv
module ukgen_ctrl_chk
  import ukgen_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        eng_phase,
  input logic              dp_prep_done,
  input logic              dp_proc_done,
  input logic              dp_post_done,
  input logic [RISK_W-1:0] dp_risk,
  input logic [2:0]        raw_bits,
  input logic [2:0]        ena_bits,
  input logic [STAT_W-1:0] status,
  input logic              irq
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_phase == 2'd0 && !dp_prep_done) |=> eng_phase == 2'd0);

  // R3
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((eng_phase == 2'd1 || eng_phase == 2'd2) && !dp_proc_done) |=> $stable(eng_phase));

  // R4
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_phase == 2'd3 && dp_post_done) |=> eng_phase == 2'd0);

  // R5
  risk_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_phase == 2'd3 && dp_post_done && dp_risk == RISK_ERR) |=> status == ST_BAD);

  // R7
  raw_set_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(raw_bits[0]) |-> $past(dp_prep_done));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw_bits & ena_bits) == 3'b000) |=> !irq);
endmodule

bind ukgen_ctrl ukgen_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .eng_phase   (eng_phase),
  .dp_prep_done(dp_prep_done),
  .dp_proc_done(dp_proc_done),
  .dp_post_done(dp_post_done),
  .dp_risk     (dp_risk),
  .raw_bits    (irq_raw),
  .ena_bits    (irq_ena),
  .status      (res_status),
  .irq         (irq)
);

// File: tb/ukgen_ctrl_test.sv
module ukgen_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        prep = 1'b0, proc_d = 1'b0, post = 1'b0;
  logic [2:0]  risk = '0;
  logic        dp_start, dp_resume, dp_mode, clk_force_reg, clk_force_mem, irq;
  logic [1:0]  eng_phase;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ukgen_ctrl uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_prep_done(prep),
    .dp_proc_done(proc_d), .dp_post_done(post), .dp_risk(risk), .dp_start(dp_start),
    .dp_resume(dp_resume), .dp_mode(dp_mode), .eng_phase(eng_phase),
    .clk_force_reg(clk_force_reg), .clk_force_mem(clk_force_mem), .irq(irq)
  );

  // {mode, risk, expected pause phase, expected status}
  localparam logic [7:0] VEC [5] = '{
    {1'b0, 3'd0, 2'd1, 2'd1},
    {1'b1, 3'd3, 2'd2, 2'd1},
    {1'b0, 3'd6, 2'd1, 2'd1},
    {1'b1, 3'd7, 2'd2, 2'd2},
    {1'b0, 3'd7, 2'd1, 2'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    prep = (which == 0); proc_d = (which == 1); post = (which == 2);
    @(negedge clk);
    prep = 1'b0; proc_d = 1'b0; post = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(8'h28, v); check("R1 phase", v, 0);
    rd(8'h08, v); check("R1 raw", v, 0);
    rd(8'h10, v); check("R1 ena", v, 0);
    rd(8'h0C, v); check("R1 masked", v, 0);
    rd(8'h20, v); check("R1 mode", v, 0);
    rd(8'h34, v); check("R1 result", v, 0);
    rd(8'h04, v); check("R1 clkctl", v, 1);
    rd(8'hFC, v); check("R1 version", v, 36720704);
    check("R1 irq", {31'b0, irq}, 0);

    // R6 mismatched pulses in IDLE without launch
    wr(8'h24, 32'h1);
    pulse(0); pulse(1); pulse(2);
    rd(8'h28, v); check("R6 idle phase", v, 0);
    rd(8'h08, v); check("R6 idle raw", v, 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 5; i++) begin
      logic       m;
      logic [2:0] rk;
      logic [1:0] ph, st;
      {m, rk, ph, st} = VEC[i];
      wr(8'h14, 32'h7);
      wr(8'h20, {31'b0, m});
      wr(8'h24, 32'h2);
      check("R2 dp_mode", {31'b0, dp_mode}, {31'b0, m});
      pulse(0);
      rd(8'h28, v); check("R2 pause phase", v, {30'b0, ph});
      rd(8'h08, v); check("R2 raw prep", v, 1);
      pulse(1);
      rd(8'h28, v); check("R6 proc before resume", v, {30'b0, ph});
      wr(8'h24, 32'h1);
      pulse(1);
      rd(8'h28, v); check("R3 busy", v, 3);
      rd(8'h08, v); check("R3 raw proc", v, 3);
      risk = rk;
      pulse(2);
      rd(8'h28, v); check("R4 idle", v, 0);
      rd(8'h08, v); check("R4 raw post", v, 7);
      rd(8'h34, v); check("R5 result", v, {27'b0, rk, st});
    end

    // R6 wrong strobes while paused in LOAD
    wr(8'h14, 32'h7);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h2);
    pulse(0);
    wr(8'h14, 32'h7);
    wr(8'h24, 32'h2);
    pulse(0); pulse(2);
    rd(8'h28, v); check("R6 load phase", v, 1);
    rd(8'h08, v); check("R6 load raw", v, 0);
    wr(8'h24, 32'h1); pulse(1); pulse(2);

    // R7 clear and set in same cycle: set wins
    wr(8'h14, 32'h7);
    wr(8'h24, 32'h2);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1; prep = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; prep = 1'b0;
    rd(8'h08, v); check("R7 set wins", v, 1);
    wr(8'h14, 32'h1);
    rd(8'h08, v); check("R7 clear", v, 0);
    wr(8'h24, 32'h1); pulse(1); pulse(2);

    // R8 masking and irq
    rd(8'h08, v); check("R8 raw", v, 6);
    check("R8 irq off when disabled", {31'b0, irq}, 0);
    wr(8'h10, 32'h1);
    @(negedge clk);
    rd(8'h0C, v); check("R8 masked none", v, 0);
    check("R8 irq off", {31'b0, irq}, 0);
    wr(8'h10, 32'h2);
    @(negedge clk);
    check("R8 irq on", {31'b0, irq}, 1);
    rd(8'h0C, v); check("R8 masked", v, 2);
    wr(8'h14, 32'h2);
    @(negedge clk);
    check("R8 irq cleared", {31'b0, irq}, 0);

    // R9 write-only and unmapped read 0
    rd(8'h24, v); check("R9 ctrl reads 0", v, 0);
    rd(8'h14, v); check("R9 clr reads 0", v, 0);
    rd(8'h40, v); check("R9 unmapped", v, 0);

    // R10 clock control
    wr(8'h04, 32'h2);
    rd(8'h04, v); check("R10 clkctl", v, 2);
    check("R10 pins", {30'b0, clk_force_mem, clk_force_reg}, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule